// File: doc/BRIEF.md
# Paged Aperture Address Remapper

This block sits on the device side of a 1 MB memory-mapped aperture and lets a host reach a 32 MB internal address space through it. Each bus request carries a 20-bit aperture offset. The lower half of the aperture is an identity map onto the bottom 512 KB of the internal space. Any access to the upper half is redirected into one of 64 pages of 512 KB each. The page comes from a window register that the block holds itself.

The window register sits at a fixed offset inside the lower half, so the host can always reach it. A write to it loads a 6-bit page number and an enable flag. A read of it returns both, so software can confirm the setting. While the flag is clear, the upper half behaves as unmapped space.

Translated accesses go out on a simple internal memory port. Each access is a single-cycle request strobe with a 25-bit word-aligned address. Reads are answered later by a response strobe carrying data. Writes are posted and get no response. Only one read may be outstanding at a time.

Top module: `aperture_pager`

## Requirements
- R1: After reset the page number and the enable flag are both zero, and neither `memReqValid` nor `respValid` is asserted. A read of the window register returns 0, and a read of the upper half returns 0xFFFFFFFF.
- R2: An access whose offset bit 19 is 0, other than one to the window register, is forwarded one cycle later with `memAddr` equal to the offset zero-extended to 25 bits.
- R3: An access whose offset word (bits [19:2]) equals that of 0x310C targets the window register and never produces a memory request. A write to it loads the page number from data bits [5:0] and the enable flag from data bit `ENABLE_POS` (30 by default, 31 in the variant).
- R4: A read of the window register raises `respValid` one cycle later. The data carries the enable flag at bit `ENABLE_POS`, the page number in bits [5:0] and zero everywhere else.
- R5: With the flag set, an upper-half access (offset bit 19 = 1) is forwarded one cycle later with `memAddr` = (page << 19) | (offset & 0x7FFFC). The write data and the write/read kind are passed along unchanged.
- R6: With the flag clear, an upper-half write is dropped: no memory request follows.
- R7: With the flag clear, an upper-half read is answered one cycle later with 0xFFFFFFFF, and no memory request is made.
- R8: Offset bits [1:0] are ignored: `memAddr` bits [1:0] are always 0, and they do not affect decoding of the window register.
- R9: A forwarded read raises `respValid` one cycle after `memRespValid`, carrying `memRdata` unchanged. Bus requests that arrive while that read is outstanding are ignored.
- R10: Write data bits other than [5:0] and `ENABLE_POS` have no effect on the window register. This includes the other candidate flag position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Bus request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | 20 | Aperture byte offset |
| reqWdata | input | 32 | Bus write data |
| respValid | output | 1 | Bus read response strobe |
| respRdata | output | 32 | Bus read response data |
| memReqValid | output | 1 | Internal memory request strobe |
| memWrite | output | 1 | Internal request kind, 1 = write |
| memAddr | output | 25 | Internal word-aligned byte address |
| memWdata | output | 32 | Internal write data |
| memRespValid | input | 1 | Internal read response strobe |
| memRdata | input | 32 | Internal read response data |

## Verification
The following results all appear one clock after the request edge:
- a memory request for a forwarded access;
- the response to a window-register read;
- the all-ones response to an unmapped read.

A forwarded read instead answers one clock after the edge that sees `memRespValid`. The bench drives and samples on falling edges, so each result is read at the first falling edge after the rising edge that produces it. The bench waits a varying number of cycles before driving `memRespValid`. At each of those waiting cycles it confirms that `respValid` is still low, which separates the response from the request timing.

// File: rtl/aperture_pkg.sv
package aperture_pkg;

  localparam int DATA_W = 32;

  typedef struct packed {
    logic winWrite;
    logic issueMem;
    logic respLocal;
    logic respUnmapped;
    logic respMem;
  } pagerStrobes_t;

endpackage

// File: rtl/aperture_pager_ctrl.sv
module aperture_pager_ctrl
  import aperture_pkg::*;
#(
  parameter int APER_W = 20,
  parameter logic [APER_W-1:0] WIN_OFFSET = 20'h0310C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [APER_W-1:0] reqOffset,
  input  logic              winEnable,
  input  logic              memRespValid,
  output logic              waitRead,
  output pagerStrobes_t     strobes
);

  logic accept;
  logic isWinReg;
  logic isUpper;

  assign accept   = reqValid && !waitRead;
  assign isWinReg = (reqOffset[APER_W-1:2] == WIN_OFFSET[APER_W-1:2]);
  assign isUpper  = reqOffset[APER_W-1];

  always_comb begin
    strobes = '0;
    if (accept) begin
      if (isWinReg) begin
        strobes.winWrite  = reqWrite;
        strobes.respLocal = !reqWrite;
      end else if (isUpper && !winEnable) begin
        strobes.respUnmapped = !reqWrite;
      end else begin
        strobes.issueMem = 1'b1;
      end
    end
    strobes.respMem = waitRead && memRespValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitRead <= 1'b0;
    end else if (strobes.issueMem && !reqWrite) begin
      waitRead <= 1'b1;
    end else if (strobes.respMem) begin
      waitRead <= 1'b0;
    end
  end

endmodule

// File: rtl/aperture_pager_dp.sv
module aperture_pager_dp
  import aperture_pkg::*;
#(
  parameter int APER_W     = 20,
  parameter int WIN_W      = 6,
  parameter int ENABLE_POS = 30,
  parameter int INT_W      = APER_W - 1 + WIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pagerStrobes_t     strobes,
  input  logic              reqWrite,
  input  logic [APER_W-1:0] reqOffset,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              winEnable,
  output logic              respValid,
  output logic [DATA_W-1:0] respRdata,
  output logic              memReqValid,
  output logic              memWrite,
  output logic [INT_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int PAGE_W = APER_W - 1;

  logic [WIN_W-1:0]  winValue;
  logic [WIN_W-1:0]  pageSel;
  logic [INT_W-1:0]  xlatAddr;
  logic [DATA_W-1:0] winReadback;
  logic [DATA_W-1:0] respNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winValue  <= '0;
      winEnable <= 1'b0;
    end else if (strobes.winWrite) begin
      winValue  <= reqWdata[WIN_W-1:0];
      winEnable <= reqWdata[ENABLE_POS];
    end
  end

  assign pageSel  = reqOffset[APER_W-1] ? winValue : '0;
  assign xlatAddr = {pageSel, reqOffset[PAGE_W-1:2], 2'b00};

  always_comb begin
    winReadback                = '0;
    winReadback[WIN_W-1:0]     = winValue;
    winReadback[ENABLE_POS]    = winEnable;
  end

  always_comb begin
    respNext = '0;
    if (strobes.respLocal)         respNext = winReadback;
    else if (strobes.respUnmapped) respNext = '1;
    else if (strobes.respMem)      respNext = memRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReqValid <= 1'b0;
      memWrite    <= 1'b0;
      memAddr     <= '0;
      memWdata    <= '0;
      respValid   <= 1'b0;
      respRdata   <= '0;
    end else begin
      memReqValid <= strobes.issueMem;
      respValid   <= strobes.respLocal | strobes.respUnmapped | strobes.respMem;
      if (strobes.issueMem) begin
        memWrite <= reqWrite;
        memAddr  <= xlatAddr;
        memWdata <= reqWdata;
      end
      if (strobes.respLocal | strobes.respUnmapped | strobes.respMem) begin
        respRdata <= respNext;
      end
    end
  end

endmodule

// File: rtl/aperture_pager.sv
module aperture_pager
  import aperture_pkg::*;
#(
  parameter int APER_W     = 20,
  parameter int WIN_W      = 6,
  parameter int ENABLE_POS = 30,
  parameter logic [APER_W-1:0] WIN_OFFSET = 20'h0310C,
  parameter int INT_W      = APER_W - 1 + WIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [APER_W-1:0] reqOffset,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              respValid,
  output logic [DATA_W-1:0] respRdata,
  output logic              memReqValid,
  output logic              memWrite,
  output logic [INT_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRdata
);

  pagerStrobes_t strobes;
  logic          waitRead;
  logic          winEnable;

  aperture_pager_ctrl #(
    .APER_W(APER_W), .WIN_OFFSET(WIN_OFFSET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .winEnable(winEnable),
    .memRespValid(memRespValid), .waitRead(waitRead), .strobes(strobes)
  );

  aperture_pager_dp #(
    .APER_W(APER_W), .WIN_W(WIN_W), .ENABLE_POS(ENABLE_POS), .INT_W(INT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqWdata(reqWdata), .memRdata(memRdata),
    .winEnable(winEnable), .respValid(respValid), .respRdata(respRdata),
    .memReqValid(memReqValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata)
  );

endmodule

// File: rtl/aperture_pager_checker.sv
module aperture_pager_checker #(
  parameter int APER_W = 20,
  parameter int INT_W  = 25,
  parameter logic [APER_W-1:0] WIN_OFFSET = 20'h0310C
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [APER_W-1:0] reqOffset,
  input logic              respValid,
  input logic [31:0]       respRdata,
  input logic              memReqValid,
  input logic [INT_W-1:0]  memAddr,
  input logic              memRespValid,
  input logic [31:0]       memRdata,
  input logic              waitRead,
  input logic              winEnable
);

  logic acc;
  logic hitWin;
  assign acc    = reqValid && !waitRead;
  assign hitWin = (reqOffset[APER_W-1:2] == WIN_OFFSET[APER_W-1:2]);

  assert_lower_passthrough_R2: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !reqOffset[APER_W-1] && !hitWin) |=>
      (memReqValid && memAddr == INT_W'({$past(reqOffset[APER_W-1:2]), 2'b00})));

  assert_win_not_forwarded_R3: assert property (@(posedge clk) disable iff (!rstN)
    (acc && hitWin) |=> !memReqValid);

  assert_unmapped_write_dropped_R6: assert property (@(posedge clk) disable iff (!rstN)
    (acc && reqWrite && reqOffset[APER_W-1] && !winEnable) |=> !memReqValid);

  assert_unmapped_read_ones_R7: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !reqWrite && reqOffset[APER_W-1] && !winEnable) |=>
      (respValid && respRdata == 32'hFFFF_FFFF && !memReqValid));

  assert_aligned_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memAddr[1:0] == 2'b00));

  assert_mem_resp_forward_R9: assert property (@(posedge clk) disable iff (!rstN)
    (waitRead && memRespValid) |=> (respValid && respRdata == $past(memRdata)));

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rstN)
    waitRead |=> !memReqValid);

endmodule

bind aperture_pager aperture_pager_checker #(
  .APER_W(APER_W), .INT_W(INT_W), .WIN_OFFSET(WIN_OFFSET)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqOffset(reqOffset), .respValid(respValid), .respRdata(respRdata),
  .memReqValid(memReqValid), .memAddr(memAddr), .memRespValid(memRespValid),
  .memRdata(memRdata), .waitRead(waitRead), .winEnable(winEnable)
);

// File: tb/aperture_pager_tb.sv
`timescale 1ns/1ps
module aperture_pager_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite;
  logic [19:0] reqOffset;
  logic [31:0] reqWdata;
  logic        respValid;
  logic [31:0] respRdata;
  logic        memReqValid, memWrite;
  logic [24:0] memAddr;
  logic [31:0] memWdata;
  logic        memRespValid;
  logic [31:0] memRdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  aperture_pager u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqWdata(reqWdata), .respValid(respValid),
    .respRdata(respRdata), .memReqValid(memReqValid), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memRespValid(memRespValid),
    .memRdata(memRdata)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memModel(logic [24:0] a);
    return {7'd0, a} * 32'd3 + 32'h1234_5678;
  endfunction

  function automatic logic [24:0] upperAddr(int w, logic [19:0] off);
    return (25'(w) << 19) | 25'(off & 20'h7FFFC);
  endfunction

  task automatic doWrite(string tag, logic [19:0] off, logic [31:0] data,
                         bit expMem, logic [24:0] expAddr);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqOffset = off; reqWdata = data;
    @(negedge clk);
    reqValid = 0;
    chk(tag, "memReqValid", 32'(memReqValid), 32'(expMem));
    if (expMem) begin
      chk(tag, "memWrite", 32'(memWrite), 32'd1);
      chk(tag, "memAddr", 32'(memAddr), 32'(expAddr));
      chk(tag, "memWdata", memWdata, data);
    end
  endtask

  task automatic doRead(string tag, logic [19:0] off, bit expMem,
                        logic [24:0] expAddr, int delay, logic [31:0] expData);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqOffset = off;
    @(negedge clk);
    reqValid = 0;
    chk(tag, "memReqValid", 32'(memReqValid), 32'(expMem));
    if (expMem) begin
      chk(tag, "memWrite", 32'(memWrite), 32'd0);
      chk(tag, "memAddr", 32'(memAddr), 32'(expAddr));
      for (int d = 0; d < delay; d++) begin
        chk("R9", "early respValid", 32'(respValid), 32'd0);
        @(negedge clk);
      end
      chk("R9", "early respValid", 32'(respValid), 32'd0);
      memRespValid = 1; memRdata = memModel(memAddr);
      @(negedge clk);
      memRespValid = 0;
    end
    chk(tag, "respValid", 32'(respValid), 32'd1);
    chk(tag, "respRdata", respRdata, expData);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      finishRun();
    end
  end

  initial begin
    rstN = 0; reqValid = 0; reqWrite = 0; reqOffset = '0; reqWdata = '0;
    memRespValid = 0; memRdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "memReqValid in reset", 32'(memReqValid), 32'd0);
    chk("R1", "respValid in reset", 32'(respValid), 32'd0);
    rstN = 1;
    doRead("R1", 20'h0310C, 0, '0, 0, 32'd0);
    doRead("R1", 20'h80010, 0, '0, 0, 32'hFFFF_FFFF);

    // R2 / R8: lower half sweep with stray low offset bits
    for (int i = 0; i < 64; i++) begin
      logic [19:0] off;
      off = 20'((i * 32'h1FFC + i) & 32'h7FFFF);
      if (off[19:2] == 18'(20'h0310C >> 2)) off = off ^ 20'h100;
      doWrite("R2", off, 32'hA500_0000 + 32'(i), 1, 25'(off & 20'hFFFFC));
      doRead("R8", off, 1, 25'(off & 20'hFFFFC), i % 3,
             memModel(25'(off & 20'hFFFFC)));
    end

    // R3 / R4 / R5 / R10: every page value with the flag set
    for (int w = 0; w < 64; w++) begin
      logic [19:0] off;
      off = 20'h80000 | 20'((w * 32'h1357 + 3) & 32'h7FFFF);
      doWrite("R3", 20'h0310C | 20'(w & 3), 32'h8000_FF00 | 32'h4000_0000 | 32'(w), 0, '0);
      doRead("R4", 20'h0310C, 0, '0, 0, 32'h4000_0000 | 32'(w));
      doWrite("R5", off, 32'h5A5A_0000 ^ 32'(w), 1, upperAddr(w, off));
      doRead("R5", off, 1, upperAddr(w, off), w % 4, memModel(upperAddr(w, off)));
    end

    // R6 / R7: flag cleared
    doWrite("R3", 20'h0310C, 32'h0000_0015, 0, '0);
    doRead("R4", 20'h0310C, 0, '0, 0, 32'h0000_0015);
    doWrite("R6", 20'hFFFFC, 32'h1111_2222, 0, '0);
    doWrite("R6", 20'h80000, 32'h3333_4444, 0, '0);
    doRead("R7", 20'hC1234, 0, '0, 0, 32'hFFFF_FFFF);
    doRead("R2", 20'h00040, 1, 25'h40, 1, memModel(25'h40));

    // R10: flag only at the other candidate position has no effect
    doWrite("R10", 20'h0310C, 32'h8000_0007, 0, '0);
    doRead("R10", 20'h0310C, 0, '0, 0, 32'h0000_0007);
    doRead("R10", 20'h90000, 0, '0, 0, 32'hFFFF_FFFF);

    // R9: requests during an outstanding read are ignored
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqOffset = 20'h00100;
    @(negedge clk);
    chk("R9", "first memReqValid", 32'(memReqValid), 32'd1);
    reqWrite = 1; reqOffset = 20'h00200; reqWdata = 32'hDEAD_BEEF;
    @(negedge clk);
    reqValid = 0;
    chk("R9", "ignored memReqValid", 32'(memReqValid), 32'd0);
    memRespValid = 1; memRdata = 32'hCAFE_0001;
    @(negedge clk);
    memRespValid = 0;
    chk("R9", "respValid", 32'(respValid), 32'd1);
    chk("R9", "respRdata", respRdata, 32'hCAFE_0001);
    @(negedge clk);
    chk("R9", "single response", 32'(respValid), 32'd0);
    chk("R9", "no late request", 32'(memReqValid), 32'd0);

    finishRun();
  end

endmodule